// File: doc/BRIEF.md
# Quadrature Encoder Up/Down Counter

This block is a 16-bit up/down counter. It counts on the system clock or on edges decoded from two encoder lines, A and B. The counter runs between zero and a programmable top value. It emits a single-cycle update pulse each time it wraps past either end.

A small register port gives software access to the block. The port performs a write on a clock edge and returns read data in the same cycle. Software selects one of four counting sources:

- the internal clock;
- A edges, with the level of B giving the direction;
- B edges, with the level of A giving the direction;
- full quadrature decoding of the A/B pair, giving four counts per encoder cycle.

The top value can be buffered, so that a new value only takes effect at the next wrap. The encoder lines are asynchronous and pass through two-flop synchronisers before edge detection.

Top module: `qenc_timer`

## Requirements
- R1: After reset the control register reads 0x0000, the mode register 0, the count 0, the top (preset) register 0xFFFF, and the update output is low.
- R2: Registers sit at byte offsets control 0x00, mode 0x08, count 0x24 and preset 0x2C. Any other offset reads 0. The mode register holds only bits [2:0], so writing 0x3F reads back 7.
- R3: Control bits are: bit 0 enable, bit 4 direction (0 = up, 1 = down), bit 7 buffered preset. With mode 0, enable set and direction up, the count rises by one each clock. A step taken from a count at or above the top value reloads 0 instead.
- R4: With mode 0, enable set and direction down, the count falls by one each clock. A step taken from 0 reloads the preset value.
- R5: With the enable bit clear, the count does not change in any mode.
- R6: In mode 1, each rising or falling edge of A steps the count: up while B is low, down while B is high. Changes of B alone do not step the count.
- R7: In mode 2, each edge of B steps the count: up while A is low, down while A is high. Changes of A alone do not step the count.
- R8: In mode 3, a change of A alone steps up when the new A differs from B. A change of B alone steps up when the new B equals A. Both cases step down otherwise. A full forward A/B cycle gives +4. A change of both inputs in the same cycle is ignored.
- R9: In modes 1 to 3, control bit 4 reads back the direction of the last decoded step, not the written bit.
- R10: With buffering on, a preset write reads back at once but takes effect as the top value only from the next wrap on.
- R11: With buffering off, a preset write takes effect as the top value from the next clock.
- R12: A write to the count register sets the count directly. It takes precedence over any step in the same cycle.
- R13: The update output is high for one clock after each wrap, whether up or down, and low otherwise.
- R14: Mode values 4 to 7 select no source, and the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the same cycle as the strobe |
| enc_a | input | 1 | Encoder line A (asynchronous) |
| enc_b | input | 1 | Encoder line B (asynchronous) |
| upd_evt | output | 1 | Single-cycle pulse on each wrap |

## Verification
A level change on an encoder line reaches the count on the third rising edge after it. Two edges go to synchronisation, and the third registers the count. The bench therefore waits five clocks after each encoder change before reading.

In internal-clock mode a run enabled for m waiting clocks by the bench yields exactly m+1 steps. This is because the disabling write lands on the edge after those clocks, and the expected counts are derived from that step count. Reads are combinational, and update pulses are registered. Both are sampled just after the falling edge, so a pulse that follows the wrap edge is always counted once.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_MODE   = 'h08;
  localparam int OFF_CNT    = 'h24;
  localparam int OFF_PRESET = 'h2C;

  localparam int BIT_EN   = 0;
  localparam int BIT_DIR  = 4;
  localparam int BIT_BUF  = 7;

  typedef enum logic [2:0] {
    SRC_CLK   = 3'd0,
    SRC_A     = 3'd1,
    SRC_B     = 3'd2,
    SRC_QUAD  = 3'd3
  } src_mode_e;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_in,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] toggled
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= async_in[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end

    assign level[i]   = s2_q;
    assign toggled[i] = s2_q ^ prev_q;
  end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       enable,
  input  logic       sw_down,
  input  logic       a_lvl,
  input  logic       b_lvl,
  input  logic       a_chg,
  input  logic       b_chg,
  output logic       step,
  output logic       step_up,
  output logic       dir_rb
);
  logic hw_down_q, hw_down_d;
  logic enc_mode;

  always_comb begin
    step    = 1'b0;
    step_up = 1'b1;
    unique case (mode)
      SRC_CLK: begin
        step    = enable;
        step_up = !sw_down;
      end
      SRC_A: begin
        step    = enable && a_chg;
        step_up = !b_lvl;
      end
      SRC_B: begin
        step    = enable && b_chg;
        step_up = !a_lvl;
      end
      SRC_QUAD: begin
        step    = enable && (a_chg ^ b_chg);
        step_up = a_chg ? (a_lvl != b_lvl) : (b_lvl == a_lvl);
      end
      default: begin
        step    = 1'b0;
        step_up = 1'b1;
      end
    endcase
  end

  assign enc_mode = (mode == SRC_A) || (mode == SRC_B) || (mode == SRC_QUAD);

  always_comb begin
    hw_down_d = hw_down_q;
    if (enc_mode && step) hw_down_d = !step_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hw_down_q <= 1'b0;
    else        hw_down_q <= hw_down_d;
  end

  assign dir_rb = enc_mode ? hw_down_q : sw_down;
endmodule

// File: rtl/qenc_count.sv
module qenc_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             step_up,
  input  logic             sw_wr,
  input  logic [CNT_W-1:0] sw_data,
  input  logic [CNT_W-1:0] preset,
  input  logic             buf_en,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] shadow,
  output logic             upd
);
  logic [CNT_W-1:0] cnt_q, cnt_d, shadow_q, shadow_d, top_eff;
  logic             upd_q, upd_d, wrap_up, wrap_dn;

  assign top_eff = buf_en ? shadow_q : preset;
  assign wrap_up = step && step_up && (cnt_q >= top_eff);
  assign wrap_dn = step && !step_up && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (sw_wr)        cnt_d = sw_data;
    else if (wrap_up) cnt_d = '0;
    else if (wrap_dn) cnt_d = preset;
    else if (step)    cnt_d = step_up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
  end

  assign upd_d    = !sw_wr && (wrap_up || wrap_dn);
  assign shadow_d = (!buf_en || upd_d) ? preset : shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shadow_q <= '1;
      upd_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      shadow_q <= shadow_d;
      upd_q    <= upd_d;
    end
  end

  assign cnt    = cnt_q;
  assign shadow = shadow_q;
  assign upd    = upd_q;
endmodule

// File: rtl/qenc_timer.sv
module qenc_timer
  import qenc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              enc_a,
  input  logic              enc_b,
  output logic              upd_evt
);
  localparam int LINES = 2;

  logic              wr_ctrl, wr_mode, wr_cnt, wr_preset;
  logic              ctrl_en_q, ctrl_dir_q, ctrl_buf_q;
  logic              ctrl_en_d, ctrl_dir_d, ctrl_buf_d;
  logic [2:0]        mode_q, mode_d;
  logic [CNT_W-1:0]  preset_q, preset_d;
  logic [LINES-1:0]  lvl, chg;
  logic              step, step_up, dir_rb;
  logic [CNT_W-1:0]  cnt_val, shadow_val;

  assign wr_ctrl   = reg_en && reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
  assign wr_mode   = reg_en && reg_wr && (reg_addr == ADDR_W'(OFF_MODE));
  assign wr_cnt    = reg_en && reg_wr && (reg_addr == ADDR_W'(OFF_CNT));
  assign wr_preset = reg_en && reg_wr && (reg_addr == ADDR_W'(OFF_PRESET));

  always_comb begin
    ctrl_en_d  = ctrl_en_q;
    ctrl_dir_d = ctrl_dir_q;
    ctrl_buf_d = ctrl_buf_q;
    mode_d     = mode_q;
    preset_d   = preset_q;
    if (wr_ctrl) begin
      ctrl_en_d  = reg_wdata[BIT_EN];
      ctrl_dir_d = reg_wdata[BIT_DIR];
      ctrl_buf_d = reg_wdata[BIT_BUF];
    end
    if (wr_mode)   mode_d   = reg_wdata[2:0];
    if (wr_preset) preset_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q  <= 1'b0;
      ctrl_dir_q <= 1'b0;
      ctrl_buf_q <= 1'b0;
      mode_q     <= 3'd0;
      preset_q   <= '1;
    end else begin
      ctrl_en_q  <= ctrl_en_d;
      ctrl_dir_q <= ctrl_dir_d;
      ctrl_buf_q <= ctrl_buf_d;
      mode_q     <= mode_d;
      preset_q   <= preset_d;
    end
  end

  qenc_sync #(.LINES(LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({enc_b, enc_a}),
    .level    (lvl),
    .toggled  (chg)
  );

  qenc_decode u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .enable  (ctrl_en_q),
    .sw_down (ctrl_dir_q),
    .a_lvl   (lvl[0]),
    .b_lvl   (lvl[1]),
    .a_chg   (chg[0]),
    .b_chg   (chg[1]),
    .step    (step),
    .step_up (step_up),
    .dir_rb  (dir_rb)
  );

  qenc_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .step_up (step_up),
    .sw_wr   (wr_cnt),
    .sw_data (reg_wdata),
    .preset  (preset_q),
    .buf_en  (ctrl_buf_q),
    .cnt     (cnt_val),
    .shadow  (shadow_val),
    .upd     (upd_evt)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_en && !reg_wr) begin
      case (reg_addr)
        ADDR_W'(OFF_CTRL): begin
          reg_rdata[BIT_EN]  = ctrl_en_q;
          reg_rdata[BIT_DIR] = dir_rb;
          reg_rdata[BIT_BUF] = ctrl_buf_q;
        end
        ADDR_W'(OFF_MODE):   reg_rdata[2:0] = mode_q;
        ADDR_W'(OFF_CNT):    reg_rdata = cnt_val;
        ADDR_W'(OFF_PRESET): reg_rdata = preset_q;
        default:             reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/qenc_timer_chk.sv
module qenc_timer_chk
  import qenc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_en,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              upd_evt,
  input logic [CNT_W-1:0]  cnt_val,
  input logic [CNT_W-1:0]  shadow_val,
  input logic [CNT_W-1:0]  preset_q,
  input logic              ctrl_en_q,
  input logic              ctrl_dir_q,
  input logic              ctrl_buf_q,
  input logic [2:0]        mode_q
);
  logic cnt_wr, preset_wr;
  assign cnt_wr    = reg_en && reg_wr && (reg_addr == ADDR_W'(OFF_CNT));
  assign preset_wr = reg_en && reg_wr && (reg_addr == ADDR_W'(OFF_PRESET));

  AST_UPD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt && !$past(preset_wr) |-> (cnt_val == '0) || (cnt_val == preset_q)); // R13

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en_q && !cnt_wr |=> $stable(cnt_val)); // R5

  AST_NO_SOURCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q > 3'd3) && !cnt_wr |=> $stable(cnt_val)); // R14

  AST_CLK_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SRC_CLK) && ctrl_en_q && !ctrl_dir_q && !cnt_wr &&
    (cnt_val < preset_q) && (cnt_val < shadow_val)
    |=> cnt_val == $past(cnt_val) + CNT_W'(1)); // R3

  AST_BUF_HOLDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_buf_q |=> upd_evt || $stable(shadow_val)); // R10
endmodule

bind qenc_timer qenc_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_en     (reg_en),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .upd_evt    (upd_evt),
  .cnt_val    (cnt_val),
  .shadow_val (shadow_val),
  .preset_q   (preset_q),
  .ctrl_en_q  (ctrl_en_q),
  .ctrl_dir_q (ctrl_dir_q),
  .ctrl_buf_q (ctrl_buf_q),
  .mode_q     (mode_q)
);

// File: tb/qenc_timer_tb.sv
module qenc_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CTRL = 6'h00, A_MODE = 6'h08, A_CNT = 6'h24, A_PRE = 6'h2C;

  logic        clk, rst_n, reg_en, reg_wr, enc_a, enc_b;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        upd_evt;
  int          checks = 0, errors = 0, upd_seen = 0;
  bit          done = 0;

  qenc_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .enc_a(enc_a), .enc_b(enc_b), .upd_evt(upd_evt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && upd_evt) upd_seen++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_en = 0; reg_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_en = 0;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, int exp);
    logic [15:0] d;
    rd(a, d);
    chk(req, int'(d), exp);
  endtask

  // enable for m waiting clocks: m+1 steps
  task automatic run(logic [15:0] ctrl, int m);
    wr(A_CTRL, ctrl);
    repeat (m) @(posedge clk);
    wr(A_CTRL, ctrl & 16'hFFFE);
  endtask

  task automatic enc(logic a, logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (5) @(posedge clk);
  endtask

  task automatic t_reset;
    chk("R1 upd", int'(upd_evt), 0);
    rd_chk("R1 ctrl", A_CTRL, 0);
    rd_chk("R1 mode", A_MODE, 0);
    rd_chk("R1 cnt", A_CNT, 0);
    rd_chk("R1 preset", A_PRE, 16'hFFFF);
  endtask

  task automatic t_map;
    wr(6'h10, 16'hABCD);
    rd_chk("R2 unmapped 0x10", 6'h10, 0);
    rd_chk("R2 unmapped 0x04", 6'h04, 0);
    wr(A_MODE, 16'h003F);
    rd_chk("R2 mode width", A_MODE, 7);
    wr(A_MODE, 16'h0000);
  endtask

  task automatic t_clk_up;
    int base;
    wr(A_PRE, 16'd4); wr(A_CNT, 0);
    base = upd_seen;
    run(16'h0001, 7);
    rd_chk("R3 count after 8 up steps", A_CNT, 3);
    chk("R13 one pulse per wrap", upd_seen - base, 1);
  endtask

  task automatic t_clk_down;
    int base;
    wr(A_CNT, 16'd2);
    base = upd_seen;
    run(16'h0011, 4);
    rd_chk("R4 count after 5 down steps", A_CNT, 2);
    chk("R4 wrap pulse", upd_seen - base, 1);
  endtask

  task automatic t_disabled;
    wr(A_CTRL, 16'h0000);
    wr(A_CNT, 16'd3);
    repeat (10) @(posedge clk);
    rd_chk("R5 held while disabled", A_CNT, 3);
  endtask

  task automatic t_swcount;
    wr(A_CNT, 16'h1234);
    rd_chk("R12 count write", A_CNT, 16'h1234);
  endtask

  task automatic t_preload;
    int base;
    wr(A_PRE, 16'd3);
    wr(A_CTRL, 16'h0080);
    wr(A_PRE, 16'd6);
    rd_chk("R10 preset readback", A_PRE, 6);
    wr(A_CNT, 0);
    base = upd_seen;
    run(16'h0081, 7);
    rd_chk("R10 new top only after wrap", A_CNT, 4);
    chk("R10 wraps", upd_seen - base, 1);
    wr(A_CTRL, 16'h0000);
    wr(A_PRE, 16'd2);
    wr(A_CNT, 0);
    run(16'h0001, 3);
    rd_chk("R11 immediate top", A_CNT, 1);
  endtask

  task automatic t_mode_a;
    wr(A_PRE, 16'hFFFF);
    wr(A_CNT, 16'd10); wr(A_MODE, 16'd1); wr(A_CTRL, 16'h0001);
    enc(1, 0); rd_chk("R6 A rise B low", A_CNT, 11);
    enc(0, 0); rd_chk("R6 A fall B low", A_CNT, 12);
    enc(0, 1); rd_chk("R6 B alone ignored", A_CNT, 12);
    enc(1, 1); rd_chk("R6 A edge B high down", A_CNT, 11);
    rd_chk("R9 decoded down", A_CTRL, 16'h0011);
    wr(A_CTRL, 0); enc(0, 0);
  endtask

  task automatic t_mode_b;
    wr(A_CNT, 16'd10); wr(A_MODE, 16'd2); wr(A_CTRL, 16'h0001);
    enc(0, 1); rd_chk("R7 B rise A low", A_CNT, 11);
    enc(0, 0); rd_chk("R7 B fall A low", A_CNT, 12);
    enc(1, 0); rd_chk("R7 A alone ignored", A_CNT, 12);
    enc(1, 1); rd_chk("R7 B edge A high down", A_CNT, 11);
    wr(A_CTRL, 0); enc(0, 0);
  endtask

  task automatic t_quad;
    wr(A_CNT, 16'd100); wr(A_MODE, 16'd3); wr(A_CTRL, 16'h0011);
    enc(1, 0); enc(1, 1); enc(0, 1); enc(0, 0);
    rd_chk("R8 forward cycle +4", A_CNT, 104);
    rd_chk("R9 decoded up", A_CTRL, 16'h0001);
    enc(1, 1); rd_chk("R8 double change ignored", A_CNT, 104);
    enc(1, 0); rd_chk("R8 reverse step", A_CNT, 103);
    rd_chk("R9 decoded down", A_CTRL, 16'h0011);
    wr(A_CTRL, 0); enc(0, 0);
  endtask

  task automatic t_nosrc;
    wr(A_CNT, 16'd7); wr(A_MODE, 16'd5); wr(A_CTRL, 16'h0001);
    enc(1, 0); enc(1, 1);
    rd_chk("R14 mode 5 holds", A_CNT, 7);
    wr(A_CTRL, 0); enc(0, 0); wr(A_MODE, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_en = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    enc_a = 0; enc_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_map();
    t_clk_up();
    t_clk_down();
    t_disabled();
    t_swcount();
    t_preload();
    t_mode_a();
    t_mode_b();
    t_quad();
    t_nosrc();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule